// File: doc/BRIEF.md
# Multi-Core Extended Interrupt Router

The router takes a parameterised set of level-sensitive interrupt sources (a multiple of 32, up to 256) and steers each one to one of several CPU cores. Each core has four parent interrupt lines. Sources are organised in 32-bit words. A group of 32 sources shares one line-select byte, which picks the parent line. Every source has its own core-select byte, which picks the core. Each core keeps its own in-service vector. A source's bit in that vector is set when the source rises while it is enabled. A parent line is the OR of all in-service bits that are routed to it.

Software reaches every register over a simple 32-bit little-endian request/response bus. Each request carries the ID of the core that issues it, and that ID selects which core's in-service vector is read or cleared. The routing reacts live to register writes:
- Enabling a source while its input is high delivers it to its core.
- Disabling a source withdraws it.
- Rewriting a pending source's core-select byte moves it from the old core to the new one.

A feature/config register pair selects how core-select bytes are decoded. Node-type and bounce words are plain storage.

Top module: `extirq_router`

## Requirements
- R1: The raw status words (offset 0x0100 + 4*w) read back the input levels registered one clock earlier. Bit i of word w is source 32*w+i. This holds whatever the enables are.
- R2: A rising input whose enable bit is clear sets no in-service bit and asserts no parent line.
- R3: The line-select byte for group g is byte g%4 of the word at 0x0200 + 4*(g/4). The index of its lowest set bit picks the parent line. A zero byte, or a lowest set bit at index 4 or above, selects line 0. Output core_irq bit 4*core+line carries that line.
- R4: The core-select byte for source s is byte s%4 of the word at 0x0300 + 4*(s/4), and it reads back as written. With config bit 1 clear, the core is the index of the byte's lowest set bit. A zero byte, or an index that is not a present core, gives core 0.
- R5: With config bit 1 set, the byte value itself is the core number, and a value that is not a present core gives core 0. The decoding applies when the byte is written.
- R6: A parent line stays high while any in-service bit routed to it is set. It falls one cycle after the last such bit clears.
- R7: A write to an enable word (0x0000 + 4*w) sets the in-service bit at the routed core for every newly enabled source whose input is high. It clears the in-service bit of every newly disabled source.
- R8: Reads and writes at 0x0400 + 4*w act on the in-service vector of the core named by bus_core_id. Writing 1 to a bit clears it. Writing 0 leaves it unchanged. An input that is still high does not set the bit again until it falls and rises.
- R9: Rewriting the core-select byte of a source whose input is high clears its in-service bit at the old core. It then sets the bit at the new core if the source is enabled.
- R10: The feature word at 0x0700 is read-only (bit 0 enable, bit 1 encoded core numbers, bit 2 virtualization extension), and a write to it answers with rsp_err. A nonzero write to the config word at 0x0704 while config bit 0 is set answers with rsp_err and leaves config unchanged. Any other config write stores the data ANDed with the features.
- R11: After reset every output is low and every enable, in-service, map and storage word is zero. Config is zero when the virtualization feature is present, and 1 (enable) otherwise.
- R12: Every request gets rsp_valid exactly one cycle later. Unmapped or unaligned offsets read zero, ignore writes and never raise rsp_err.
- R13: A falling input clears its in-service bit at every core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | NUM_SRC | Interrupt source levels |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_core_id | input | CW | ID of the requesting core |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| rsp_err | output | 1 | Request rejected |
| core_irq | output | NUM_CORES*4 | Parent lines, bit 4*core+line |

## Verification
The bench moves a pending source between cores with a core-select rewrite. A design that forgets the withdrawal would leave the old core's line stuck high. It also toggles an enable word both while a source is pending and before a disabled source is raised. Missing replay would lose the interrupt, and missing withdrawal would keep a masked source visible. A write-1-to-clear is checked against a second source on the same line, which must keep the line up. The bench also checks that an in-service write from another core's ID touches nothing, which catches an OR-reduced line that drops early or a clear that hits the wrong core. A table of line-select bytes probes every branch of the lowest-set-bit decode, including the zero and out-of-range fallbacks. The bench also covers the locked-config rejection and the read-only feature word.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  localparam int NUM_LINES = 4;

  typedef enum logic [3:0] {
    RG_NONE, RG_EN, RG_RAW, RG_LSEL, RG_CSEL,
    RG_ISR, RG_NTYPE, RG_BOUNCE, RG_FEAT, RG_CFG
  } region_e;

  // lowest set bit among the four low bits; anything else selects 0
  function automatic logic [1:0] low_line(input logic [7:0] b);
    if (b[0])      return 2'd0;
    else if (b[1]) return 2'd1;
    else if (b[2]) return 2'd2;
    else if (b[3]) return 2'd3;
    else           return 2'd0;
  endfunction

endpackage

// File: rtl/extirq_decode.sv
module extirq_decode
  import extirq_pkg::*;
#(
  parameter int N_WORDS     = 2,
  parameter int MAP_WORDS   = 16,
  parameter int LSEL_WORDS  = 1,
  parameter int NTYPE_WORDS = 4
) (
  input  logic [15:0] addr,
  output region_e     region,
  output logic [5:0]  idx
);

  always_comb begin
    idx    = addr[7:2];
    region = RG_NONE;
    if (addr[1:0] == 2'b00) begin
      case (addr[15:8])
        8'h00: if (int'(idx) < N_WORDS)     region = RG_EN;
        8'h01: if (int'(idx) < N_WORDS)     region = RG_RAW;
        8'h02: if (int'(idx) < LSEL_WORDS)  region = RG_LSEL;
        8'h03: if (int'(idx) < MAP_WORDS)   region = RG_CSEL;
        8'h04: if (int'(idx) < N_WORDS)     region = RG_ISR;
        8'h05: if (int'(idx) < NTYPE_WORDS) region = RG_NTYPE;
        8'h06: if (int'(idx) < N_WORDS)     region = RG_BOUNCE;
        8'h07: begin
          if (idx == 6'd0)      region = RG_FEAT;
          else if (idx == 6'd1) region = RG_CFG;
        end
        default: region = RG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/extirq_pending.sv
module extirq_pending
  import extirq_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int NUM_CORES = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [NUM_CORES-1:0][NUM_SRC-1:0]   bus_set,
  input  logic [NUM_CORES-1:0][NUM_SRC-1:0]   bus_clr,
  input  logic [NUM_CORES-1:0][NUM_SRC-1:0]   edge_set,
  input  logic [NUM_CORES-1:0][NUM_SRC-1:0]   edge_clr,
  input  logic [NUM_SRC-1:0][1:0]             src_line,
  output logic [NUM_CORES-1:0][NUM_SRC-1:0]   isr_q,
  output logic [NUM_CORES*NUM_LINES-1:0]      irq_q
);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [NUM_LINES-1:0] line_d;

    always_ff @(posedge clk) begin
      if (rst) isr_q[c] <= '0;
      else     isr_q[c] <= (((isr_q[c] & ~bus_clr[c]) | bus_set[c]) & ~edge_clr[c]) | edge_set[c];
    end

    always_comb begin
      line_d = '0;
      for (int l = 0; l < NUM_LINES; l++)
        for (int s = 0; s < NUM_SRC; s++)
          if (isr_q[c][s] && int'(src_line[s]) == l) line_d[l] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst) irq_q[c*NUM_LINES +: NUM_LINES] <= '0;
      else     irq_q[c*NUM_LINES +: NUM_LINES] <= line_d;
    end
  end

endmodule

// File: rtl/extirq_router.sv
module extirq_router
  import extirq_pkg::*;
#(
  parameter int NUM_SRC     = 64,
  parameter int NUM_CORES   = 2,
  parameter int NTYPE_WORDS = 4,
  parameter bit HAS_VIRT    = 1'b1,
  localparam int CW         = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_SRC-1:0]             src_level,
  input  logic                           bus_valid,
  input  logic                           bus_write,
  input  logic [15:0]                    bus_addr,
  input  logic [31:0]                    bus_wdata,
  input  logic [CW-1:0]                  bus_core_id,
  output logic                           rsp_valid,
  output logic [31:0]                    rsp_rdata,
  output logic                           rsp_err,
  output logic [NUM_CORES*NUM_LINES-1:0] core_irq
);

  localparam int N_WORDS    = NUM_SRC / 32;
  localparam int MAP_WORDS  = NUM_SRC / 4;
  localparam int LSEL_WORDS = (N_WORDS + 3) / 4;
  localparam logic [31:0] FEATURES = {29'd0, HAS_VIRT, 1'b1, 1'b1};
  localparam logic [31:0] CFG_RST  = HAS_VIRT ? 32'd0 : 32'd1;
  localparam int CFG_ON  = 0;
  localparam int CFG_ENC = 1;

  // state
  logic [NUM_SRC-1:0]               raw_q, en_q, en_d;
  logic [N_WORDS-1:0][7:0]          lsel_q;
  logic [NUM_SRC-1:0][7:0]          csel_q;
  logic [NUM_SRC-1:0][CW-1:0]       core_q, core_d;
  logic [NTYPE_WORDS-1:0][31:0]     ntype_q;
  logic [N_WORDS-1:0][31:0]         bounce_q;
  logic [31:0]                      cfg_q;

  logic [NUM_CORES-1:0][NUM_SRC-1:0] bus_set, bus_clr, edge_set, edge_clr, isr_all;
  logic [NUM_SRC-1:0][1:0]          src_line;

  region_e     rg;
  logic [5:0]  rg_idx;
  logic        wr, en_wr, csel_wr, isr_wr;
  logic [31:0] rd_d;
  logic        err_d;

  function automatic logic [CW-1:0] pick_core(input logic [7:0] b, input logic enc);
    int v;
    if (enc) v = int'(b);
    else     v = int'(low_line(b)) + ((b[3:0] == 4'd0) ? 0 : 0);
    if (!enc && b[3:0] == 4'd0) v = 0;
    if (v >= NUM_CORES) v = 0;
    return CW'(v);
  endfunction

  extirq_decode #(
    .N_WORDS(N_WORDS), .MAP_WORDS(MAP_WORDS),
    .LSEL_WORDS(LSEL_WORDS), .NTYPE_WORDS(NTYPE_WORDS)
  ) dec_i (
    .addr(bus_addr), .region(rg), .idx(rg_idx)
  );

  assign wr      = bus_valid && bus_write;
  assign en_wr   = wr && rg == RG_EN;
  assign csel_wr = wr && rg == RG_CSEL;
  assign isr_wr  = wr && rg == RG_ISR;

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) src_line[s] = low_line(lsel_q[s/32]);
  end

  // next enable and decoded core values
  always_comb begin
    en_d   = en_q;
    core_d = core_q;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (en_wr && s/32 == int'(rg_idx)) en_d[s] = bus_wdata[s%32];
      if (csel_wr && s/4 == int'(rg_idx))
        core_d[s] = pick_core(bus_wdata[8*(s%4) +: 8], cfg_q[CFG_ENC]);
    end
  end

  // set/clear events per core and source
  always_comb begin
    bus_set  = '0;
    bus_clr  = '0;
    edge_set = '0;
    edge_clr = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (en_d[s] && !en_q[s] && raw_q[s] && int'(core_q[s]) == c) bus_set[c][s] = 1'b1;
        if (!en_d[s] && en_q[s]) bus_clr[c][s] = 1'b1;
        if (isr_wr && int'(bus_core_id) == c && s/32 == int'(rg_idx) && bus_wdata[s%32])
          bus_clr[c][s] = 1'b1;
        if (core_d[s] != core_q[s] && raw_q[s]) begin
          if (int'(core_q[s]) == c) bus_clr[c][s] = 1'b1;
          if (int'(core_d[s]) == c && en_q[s]) bus_set[c][s] = 1'b1;
        end
        if (src_level[s] && !raw_q[s] && en_d[s] && int'(core_d[s]) == c) edge_set[c][s] = 1'b1;
        if (!src_level[s] && raw_q[s]) edge_clr[c][s] = 1'b1;
      end
    end
  end

  extirq_pending #(.NUM_SRC(NUM_SRC), .NUM_CORES(NUM_CORES)) pend_i (
    .clk(clk), .rst(rst),
    .bus_set(bus_set), .bus_clr(bus_clr),
    .edge_set(edge_set), .edge_clr(edge_clr),
    .src_line(src_line), .isr_q(isr_all), .irq_q(core_irq)
  );

  // read mux and error decision
  always_comb begin
    rd_d  = '0;
    err_d = 1'b0;
    case (rg)
      RG_EN:  for (int s = 0; s < NUM_SRC; s++) if (s/32 == int'(rg_idx)) rd_d[s%32] = en_q[s];
      RG_RAW: for (int s = 0; s < NUM_SRC; s++) if (s/32 == int'(rg_idx)) rd_d[s%32] = raw_q[s];
      RG_LSEL:
        for (int g = 0; g < N_WORDS; g++)
          if (g/4 == int'(rg_idx)) rd_d[8*(g%4) +: 8] = lsel_q[g];
      RG_CSEL:
        for (int s = 0; s < NUM_SRC; s++)
          if (s/4 == int'(rg_idx)) rd_d[8*(s%4) +: 8] = csel_q[s];
      RG_ISR:
        for (int c = 0; c < NUM_CORES; c++)
          for (int s = 0; s < NUM_SRC; s++)
            if (int'(bus_core_id) == c && s/32 == int'(rg_idx)) rd_d[s%32] = isr_all[c][s];
      RG_NTYPE:  for (int k = 0; k < NTYPE_WORDS; k++) if (k == int'(rg_idx)) rd_d = ntype_q[k];
      RG_BOUNCE: for (int k = 0; k < N_WORDS; k++) if (k == int'(rg_idx)) rd_d = bounce_q[k];
      RG_FEAT: begin
        rd_d  = FEATURES;
        err_d = bus_write;
      end
      RG_CFG: begin
        rd_d  = cfg_q;
        err_d = bus_write && cfg_q[CFG_ON] && bus_wdata != 32'd0;
      end
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q    <= '0;
      en_q     <= '0;
      core_q   <= '0;
      lsel_q   <= '0;
      csel_q   <= '0;
      ntype_q  <= '0;
      bounce_q <= '0;
      cfg_q    <= CFG_RST;
    end else begin
      raw_q  <= src_level;
      en_q   <= en_d;
      core_q <= core_d;
      if (wr && rg == RG_LSEL)
        for (int g = 0; g < N_WORDS; g++)
          if (g/4 == int'(rg_idx)) lsel_q[g] <= bus_wdata[8*(g%4) +: 8];
      if (csel_wr)
        for (int s = 0; s < NUM_SRC; s++)
          if (s/4 == int'(rg_idx)) csel_q[s] <= bus_wdata[8*(s%4) +: 8];
      if (wr && rg == RG_NTYPE)
        for (int k = 0; k < NTYPE_WORDS; k++) if (k == int'(rg_idx)) ntype_q[k] <= bus_wdata;
      if (wr && rg == RG_BOUNCE)
        for (int k = 0; k < N_WORDS; k++) if (k == int'(rg_idx)) bounce_q[k] <= bus_wdata;
      if (wr && rg == RG_CFG && !err_d) cfg_q <= bus_wdata & FEATURES;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= bus_valid;
      rsp_rdata <= (bus_valid && !bus_write) ? rd_d : 32'd0;
      rsp_err   <= bus_valid && err_d;
    end
  end

endmodule

// File: rtl/extirq_router_chk.sv
module extirq_router_chk #(
  parameter int NUM_SRC   = 64,
  parameter int NUM_CORES = 2
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              bus_valid,
  input logic                              bus_write,
  input logic [15:0]                       bus_addr,
  input logic [31:0]                       bus_wdata,
  input logic                              rsp_valid,
  input logic                              rsp_err,
  input logic [NUM_CORES*4-1:0]            core_irq,
  input logic [31:0]                       cfg,
  input logic [NUM_CORES-1:0][NUM_SRC-1:0] isr
);

  assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> rsp_valid);

  assert_rsp_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !rsp_valid);

  assert_unmapped_no_err_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_addr[15:11] != 5'd0) |=> !rsp_err);

  assert_feat_readonly_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_addr == 16'h0700) |=> rsp_err);

  assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write && bus_addr == 16'h0704 && cfg[0] && bus_wdata != 32'd0)
      |=> (rsp_err && $stable(cfg)));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    assert_line_held_R6: assert property (@(posedge clk) disable iff (rst)
      (|isr[c]) |=> (|core_irq[c*4 +: 4]));
    assert_line_dropped_R6: assert property (@(posedge clk) disable iff (rst)
      !(|isr[c]) |=> (core_irq[c*4 +: 4] == 4'd0));
  end

endmodule

bind extirq_router extirq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_CORES(NUM_CORES)) chk_i (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .core_irq(core_irq), .cfg(cfg_q), .isr(isr_all)
);

// File: tb/extirq_router_tb.sv
module extirq_router_tb_top;

  localparam int CLK_PERIOD = 10;

  localparam logic [15:0] A_EN   = 16'h0000;
  localparam logic [15:0] A_RAW  = 16'h0100;
  localparam logic [15:0] A_LSEL = 16'h0200;
  localparam logic [15:0] A_CSEL = 16'h0300;
  localparam logic [15:0] A_ISR  = 16'h0400;
  localparam logic [15:0] A_FEAT = 16'h0700;
  localparam logic [15:0] A_CFG  = 16'h0704;

  // high byte: line-select value for group 0, low byte: expected line
  localparam logic [15:0] LSEL_TAB [9] = '{
    16'h0000, 16'h0100, 16'h0201, 16'h0601, 16'h0402,
    16'h0803, 16'h1000, 16'h8000, 16'h0C02
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_level = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [0:0]  bus_core_id = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [7:0]  core_irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] rd;
  logic        er;

  always #(CLK_PERIOD/2) clk = ~clk;

  extirq_router dut_i (
    .clk(clk), .rst(rst), .src_level(src_level),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_core_id(bus_core_id),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .core_irq(core_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic w, input logic [15:0] a, input logic [31:0] d,
                      input logic [0:0] cid, output logic [31:0] r, output logic e);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d; bus_core_id = cid;
    @(negedge clk);
    r = rsp_rdata; e = rsp_err;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [0:0] cid);
    logic [31:0] r; logic e;
    xfer(1'b1, a, d, cid, r, e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    n_fail++;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);

    // R11 reset state
    check("R11 irq after reset", {24'd0, core_irq}, 32'd0);
    xfer(0, A_CFG, 0, 0, rd, er);  check("R11 config reset", rd, 32'd0);
    xfer(0, A_EN, 0, 0, rd, er);   check("R11 enable reset", rd, 32'd0);
    xfer(0, A_FEAT, 0, 0, rd, er); check("R10 feature value", rd, 32'd7);

    // R1 raw status, R2 disabled sources stay quiet
    src_level = 64'h8000_0001_0000_0010;
    tick(1);
    xfer(0, A_RAW, 0, 0, rd, er);       check("R1 raw word0", rd, 32'h0000_0010);
    xfer(0, A_RAW + 4, 0, 0, rd, er);   check("R1 raw word1", rd, 32'h8000_0001);
    check("R2 disabled no irq", {24'd0, core_irq}, 32'd0);
    xfer(0, A_ISR, 0, 0, rd, er);       check("R2 disabled no isr", rd, 32'd0);
    src_level = '0;
    tick(2);

    wr(A_EN, 32'hFFFF_FFFF, 0);
    wr(A_EN + 4, 32'hFFFF_FFFF, 0);
    tick(1);
    check("R7 enable with inputs low", {24'd0, core_irq}, 32'd0);

    // R3 line decode table
    for (int i = 0; i < 9; i++) begin
      wr(A_LSEL, {24'd0, LSEL_TAB[i][15:8]}, 0);
      src_level[0] = 1'b1;
      tick(2);
      check($sformatf("R3 line byte %h", LSEL_TAB[i][15:8]), {24'd0, core_irq},
            32'd1 << LSEL_TAB[i][1:0]);
      src_level[0] = 1'b0;
      tick(2);
    end
    wr(A_LSEL, 32'h0000_0801, 0);

    // R6 / R8 shared line, write-one-to-clear
    src_level[2:1] = 2'b11;
    tick(2);
    check("R6 two sources line up", {24'd0, core_irq}, 32'h01);
    xfer(0, A_ISR, 0, 0, rd, er); check("R8 isr core0", rd, 32'h6);
    xfer(0, A_ISR, 0, 1, rd, er); check("R8 isr core1 empty", rd, 32'h0);
    wr(A_ISR, 32'h2, 0);
    tick(1);
    check("R6 line held by other source", {24'd0, core_irq}, 32'h01);
    xfer(0, A_ISR, 0, 0, rd, er); check("R8 w1c cleared one", rd, 32'h4);
    wr(A_ISR, 32'h0, 0);
    xfer(0, A_ISR, 0, 0, rd, er); check("R8 write zero keeps", rd, 32'h4);
    wr(A_ISR, 32'h4, 1);
    xfer(0, A_ISR, 0, 0, rd, er); check("R8 other core id no effect", rd, 32'h4);
    wr(A_ISR, 32'h4, 0);
    tick(1);
    check("R6 last source cleared", {24'd0, core_irq}, 32'h00);
    src_level[2:1] = 2'b00;
    tick(2);

    // R13 falling level
    src_level[1] = 1'b1; tick(2);
    check("R13 raise", {24'd0, core_irq}, 32'h01);
    src_level[1] = 1'b0; tick(2);
    check("R13 fall drops line", {24'd0, core_irq}, 32'h00);

    // R4 one-hot core select
    wr(A_CSEL + 4, 32'h000A_0402, 0);
    xfer(0, A_CSEL + 4, 0, 0, rd, er); check("R4 csel readback", rd, 32'h000A_0402);
    src_level[4] = 1'b1; tick(2);
    check("R4 byte 02 to core1", {24'd0, core_irq}, 32'h10);
    src_level[5] = 1'b1; tick(2);
    check("R4 byte 04 falls back to core0", {24'd0, core_irq}, 32'h11);
    src_level[5] = 1'b0; tick(2);

    // R9 live remap of pending source 4 to core0
    wr(A_CSEL + 4, 32'h000A_0401, 0);
    tick(1);
    check("R9 moved to core0", {24'd0, core_irq}, 32'h01);
    xfer(0, A_ISR, 0, 1, rd, er); check("R9 old core cleared", rd, 32'h0);
    xfer(0, A_ISR, 0, 0, rd, er); check("R9 new core set", rd, 32'h10);

    // R7 disable and re-enable while pending
    wr(A_EN, ~32'h10, 0);
    tick(1);
    check("R7 disable withdraws", {24'd0, core_irq}, 32'h00);
    xfer(0, A_ISR, 0, 0, rd, er); check("R7 isr cleared", rd, 32'h0);
    wr(A_EN, 32'hFFFF_FFFF, 0);
    tick(1);
    check("R7 re-enable replays", {24'd0, core_irq}, 32'h01);
    src_level[4] = 1'b0; tick(2);
    wr(A_EN, 32'h0, 0);
    src_level[6] = 1'b1; tick(2);
    check("R2 raised while disabled", {24'd0, core_irq}, 32'h00);
    wr(A_EN, 32'hFFFF_FFFF, 0);
    tick(1);
    check("R7 enable delivers to core1", {24'd0, core_irq}, 32'h10);
    src_level[6] = 1'b0; tick(2);

    // R5 encoded core numbers
    xfer(1, A_CFG, 32'h2, 0, rd, er); check("R10 cfg write ok", {31'd0, er}, 32'd0);
    xfer(0, A_CFG, 0, 0, rd, er);     check("R5 cfg encoded bit", rd, 32'h2);
    wr(A_CSEL + 8, 32'h0000_0501, 0);
    src_level[9:8] = 2'b11; tick(2);
    check("R5 value1 core1, value5 core0", {24'd0, core_irq}, 32'h11);
    src_level[9:8] = 2'b00; tick(2);

    // R10 feature and config rules
    xfer(1, A_FEAT, 32'h0, 0, rd, er); check("R10 feature write err", {31'd0, er}, 32'd1);
    xfer(1, A_CFG, 32'hF, 0, rd, er);  check("R10 cfg masked ok", {31'd0, er}, 32'd0);
    xfer(0, A_CFG, 0, 0, rd, er);      check("R10 cfg masked value", rd, 32'h7);
    xfer(1, A_CFG, 32'h2, 0, rd, er);  check("R10 locked cfg err", {31'd0, er}, 32'd1);
    xfer(0, A_CFG, 0, 0, rd, er);      check("R10 locked cfg kept", rd, 32'h7);
    xfer(1, A_CFG, 32'h0, 0, rd, er);  check("R10 cfg zero accepted", {31'd0, er}, 32'd0);

    // R12 unmapped and response timing
    xfer(0, 16'h0800, 0, 0, rd, er);
    check("R12 unmapped read zero", rd, 32'd0);
    check("R12 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    xfer(1, 16'h0800, 32'hFFFF_FFFF, 0, rd, er); check("R12 unmapped write no err", {31'd0, er}, 32'd0);
    xfer(0, A_EN + 1, 0, 0, rd, er);  check("R12 unaligned read zero", rd, 32'd0);
    tick(1);
    check("R12 idle no rsp", {31'd0, rsp_valid}, 32'd0);

    // R3 second group routed to line 3 (one-hot mode again)
    src_level[40] = 1'b1; tick(2);
    check("R3 group1 line3", {24'd0, core_irq}, 32'h08);

    // R11 reset mid-run
    rst = 1'b1; tick(1);
    check("R11 irq cleared by reset", {24'd0, core_irq}, 32'h00);
    rst = 1'b0; tick(2);
    check("R11 stays low after reset", {24'd0, core_irq}, 32'h00);
    xfer(0, A_CSEL + 4, 0, 0, rd, er); check("R11 csel cleared", rd, 32'h0);
    src_level = '0;
    tick(2);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule